// File: doc/BRIEF.md
# Control Endpoint Data-Stage Counter

This block holds the data-stage byte count of a USB control endpoint whose packet buffer is small, and it decides when the endpoint is armed. The CPU writes a 16-bit count as two byte registers. Writing the low byte is the arming event, so firmware writes the high byte first. The same two registers report the received byte count after an OUT data stage.

IN data can leave the endpoint in two ways. In direct mode, firmware has already filled the buffer, and the low-byte write releases a single packet. In pointer mode, the low-byte write starts a walk over a memory block. The walk begins at a supplied start address and covers a 16-bit total. The block emits the data as back-to-back packets of up to the maximum packet size and presents the read address of each packet. A zero-length packet follows only when needed.

The USB serial engine sees a level `pkt_req_o` together with `pkt_len_o`. It answers with a one-cycle `pkt_done_i` pulse when each packet completes. For OUT packets, the engine also supplies the received length on `rx_len_i`.

Top module: `ctl_ep_count`

## Requirements
- R1: After reset, both count bytes read 0, `busy_o` is 0 and `pkt_req_o` is 0.
- R2: While idle, a write with `reg_sel_i`=0 stores `reg_wdata_i` into the high byte. The high byte keeps that value through later low-byte writes and IN transfers until it is written again.
- R3: While idle, a write with `reg_sel_i`=1 stores the low byte and arms the endpoint. `busy_o` and `pkt_req_o` are 1 from the next cycle. A high-byte write never arms.
- R4: In direct IN mode (`dir_in_i`=1, `ptr_mode_i`=0), arming succeeds only when {high,low} ≤ MPS. A successful arm produces one packet of length equal to the low byte, with `rd_addr_o`=0. An out-of-range count stores the byte but leaves `busy_o` at 0.
- R5: In pointer mode (`dir_in_i`=1, `ptr_mode_i`=1), the total {high,low} is sent as packets of MPS bytes followed by one packet with the remainder. The first `rd_addr_o` is `base_addr_i`, and each later packet starts at the previous address plus the previous length.
- R6: In pointer mode, when the last data packet is exactly MPS bytes, a zero-length packet follows only if the total is less than `host_len_i`. A total of 0 sends one zero-length packet.
- R7: In OUT mode (`dir_in_i`=0), any low-byte value arms reception, and `pkt_len_o` shows MPS as the capacity. On `pkt_done_i` the low byte becomes `rx_len_i`, the high byte becomes 0, and `busy_o` clears.
- R8: `busy_o` stays 1 from arming until the cycle after the final packet's `pkt_done_i`. Writes to either count byte while busy change nothing and do not re-arm.
- R9: `pkt_done_i` has no effect while no packet is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Count register write strobe |
| reg_sel_i | input | 1 | 0 = high byte, 1 = low byte (arms) |
| reg_wdata_i | input | 8 | Write data |
| dir_in_i | input | 1 | 1 = IN data stage, 0 = OUT |
| ptr_mode_i | input | 1 | 1 = pointer walk over memory for IN |
| base_addr_i | input | ADDR_W | Start address of the pointer-mode block |
| host_len_i | input | 16 | Length requested by the host in the setup stage |
| pkt_done_i | input | 1 | Current packet completed (one-cycle pulse) |
| rx_len_i | input | PKT_W | Bytes received in the completed OUT packet |
| cnt_hi_o | output | 8 | High count byte |
| cnt_lo_o | output | 8 | Low count byte |
| busy_o | output | 1 | Transfer armed and not finished |
| pkt_req_o | output | 1 | A packet is requested from the serial engine |
| pkt_len_o | output | PKT_W | Length of requested packet (capacity for OUT) |
| rd_addr_o | output | ADDR_W | Read address of the current IN packet |

## Verification
The bench builds the block with MPS=8 and ADDR_W=16. At that size, the direct-mode limit and the first illegal count (9) are one apart. A pointer walk with a remainder, an exact multiple with and without the trailing zero-length packet, and a 259-byte walk of 33 packets all finish in a few hundred cycles. A 16-bit total still spans the high byte, so the split of the count across both registers and the address stepping are both exercised.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IN   = 2'd1,
    ST_OUT  = 2'd2
  } ep_state_e;

  localparam logic SEL_HI = 1'b0;
  localparam logic SEL_LO = 1'b1;
endpackage

// File: rtl/ctl_ep_regs.sv
module ctl_ep_regs
  import ctl_ep_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              load_rx_i,
  input  logic [BYTE_W-1:0] rx_cnt_i,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic              arm_o,
  output logic [CNT_W-1:0]  arm_total_o
);
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              wr_ok;

  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_rx_i) begin
      hi_q <= '0;
      lo_q <= rx_cnt_i;
    end else if (wr_ok) begin
      if (sel_i == SEL_HI) hi_q <= wdata_i;
      else                 lo_q <= wdata_i;
    end
  end

  // low-byte write is the arming event; total uses the fresh low byte
  assign arm_o       = wr_ok && (sel_i == SEL_LO);
  assign arm_total_o = {hi_q, wdata_i};
  assign cnt_hi_o    = hi_q;
  assign cnt_lo_o    = lo_q;

  p_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !load_rx_i) |=> ($stable(cnt_hi_o) && $stable(cnt_lo_o)));

  p_hi_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_rx_i && !(we_i && sel_i == SEL_HI)) |=> $stable(cnt_hi_o));
endmodule

// File: rtl/ctl_ep_pkt_size.sv
module ctl_ep_pkt_size #(
  parameter int MPS   = 64,
  parameter int CNT_W = 16,
  localparam int PKT_W = $clog2(MPS + 1)
) (
  input  logic [CNT_W-1:0] remain_i,
  output logic [PKT_W-1:0] len_o,
  output logic             full_o
);
  always_comb begin
    if (remain_i >= CNT_W'(MPS)) len_o = PKT_W'(MPS);
    else                         len_o = remain_i[PKT_W-1:0];
  end

  assign full_o = (len_o == PKT_W'(MPS));
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
#(
  parameter int MPS    = 64,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16,
  localparam int PKT_W = $clog2(MPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  arm_total_i,
  input  logic              dir_in_i,
  input  logic              ptr_mode_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  host_len_i,
  input  logic              pkt_done_i,
  output logic              busy_o,
  output logic              pkt_req_o,
  output logic [PKT_W-1:0]  pkt_len_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              load_rx_o
);
  ep_state_e         state_q;
  logic [CNT_W-1:0]  remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic              zlp_q;

  logic [PKT_W-1:0]  in_len;
  logic              in_full;
  logic [CNT_W-1:0]  rem_next;
  logic              last_pkt;
  logic              direct_ok;

  ctl_ep_pkt_size #(.MPS(MPS), .CNT_W(CNT_W)) u_size (
    .remain_i (remain_q),
    .len_o    (in_len),
    .full_o   (in_full)
  );

  assign rem_next  = remain_q - CNT_W'(in_len);
  // a short packet always ends; a full one ends unless data or a ZLP is left
  assign last_pkt  = !in_full || ((rem_next == '0) && !zlp_q);
  assign direct_ok = (arm_total_i <= CNT_W'(MPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      addr_q   <= '0;
      zlp_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arm_i) begin
            if (!dir_in_i) begin
              state_q <= ST_OUT;
            end else if (ptr_mode_i) begin
              state_q  <= ST_IN;
              remain_q <= arm_total_i;
              addr_q   <= base_addr_i;
              zlp_q    <= (arm_total_i < host_len_i);
            end else if (direct_ok) begin
              state_q  <= ST_IN;
              remain_q <= arm_total_i;
              addr_q   <= '0;
              zlp_q    <= 1'b0;
            end
          end
        end
        ST_IN: begin
          if (pkt_done_i) begin
            remain_q <= rem_next;
            addr_q   <= addr_q + ADDR_W'(in_len);
            if (last_pkt) state_q <= ST_IDLE;
          end
        end
        ST_OUT: begin
          if (pkt_done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign pkt_req_o = busy_o;
  assign pkt_len_o = (state_q == ST_OUT) ? PKT_W'(MPS) : in_len;
  assign rd_addr_o = addr_q;
  assign load_rx_o = (state_q == ST_OUT) && pkt_done_i;

  p_len_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_req_o |-> (pkt_len_o <= PKT_W'(MPS)));

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IN && pkt_done_i && !last_pkt)
      |=> (rd_addr_o == $past(rd_addr_o + ADDR_W'(pkt_len_o))));

  p_short_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IN && pkt_done_i && !in_full) |=> !busy_o);

  p_arm_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !busy_o && (!dir_in_i || ptr_mode_i)) |=> busy_o);

  p_idle_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !arm_i) |=> !busy_o);
endmodule

// File: rtl/ctl_ep_count.sv
module ctl_ep_count #(
  parameter int MPS    = 64,
  parameter int ADDR_W = 16,
  localparam int BYTE_W = 8,
  localparam int CNT_W  = 2 * BYTE_W,
  localparam int PKT_W  = $clog2(MPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              dir_in_i,
  input  logic              ptr_mode_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  host_len_i,
  input  logic              pkt_done_i,
  input  logic [PKT_W-1:0]  rx_len_i,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic              busy_o,
  output logic              pkt_req_o,
  output logic [PKT_W-1:0]  pkt_len_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic             arm;
  logic [CNT_W-1:0] arm_total;
  logic             load_rx;

  ctl_ep_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy_o),
    .load_rx_i   (load_rx),
    .rx_cnt_i    (BYTE_W'(rx_len_i)),
    .cnt_hi_o    (cnt_hi_o),
    .cnt_lo_o    (cnt_lo_o),
    .arm_o       (arm),
    .arm_total_o (arm_total)
  );

  ctl_ep_seq #(.MPS(MPS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .arm_total_i (arm_total),
    .dir_in_i    (dir_in_i),
    .ptr_mode_i  (ptr_mode_i),
    .base_addr_i (base_addr_i),
    .host_len_i  (host_len_i),
    .pkt_done_i  (pkt_done_i),
    .busy_o      (busy_o),
    .pkt_req_o   (pkt_req_o),
    .pkt_len_o   (pkt_len_o),
    .rd_addr_o   (rd_addr_o),
    .load_rx_o   (load_rx)
  );

  p_out_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_rx |=> (cnt_hi_o == '0 && cnt_lo_o == $past(BYTE_W'(rx_len_i)) && !busy_o));
endmodule

// File: tb/ctl_ep_count_tb.sv
module ctl_ep_count_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MPS        = 8;
  localparam int ADDR_W     = 16;
  localparam int PKT_W      = $clog2(MPS + 1);

  typedef struct packed {
    logic        ptr;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] hlen;
    logic [15:0] base;
    logic [7:0]  npk;
    logic [7:0]  last;
    logic        arm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 8'h05, 16'h0000, 16'h0000, 8'd1,  8'd5, 1'b1}, // R4 direct
    '{1'b0, 8'h00, 8'h08, 16'h0000, 16'h0000, 8'd1,  8'd8, 1'b1}, // R4 at limit
    '{1'b0, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'd1,  8'd0, 1'b1}, // R4 zero
    '{1'b0, 8'h00, 8'h09, 16'h0000, 16'h0000, 8'd0,  8'd0, 1'b0}, // R4 over limit
    '{1'b0, 8'h01, 8'h00, 16'h0000, 16'h0000, 8'd0,  8'd0, 1'b0}, // R4 high nonzero
    '{1'b1, 8'h00, 8'd20, 16'd64,   16'h0100, 8'd3,  8'd4, 1'b1}, // R5 remainder
    '{1'b1, 8'h00, 8'd16, 16'd64,   16'h0200, 8'd3,  8'd0, 1'b1}, // R6 ZLP
    '{1'b1, 8'h00, 8'd16, 16'd16,   16'h0300, 8'd2,  8'd8, 1'b1}, // R6 no ZLP
    '{1'b1, 8'h00, 8'h00, 16'd5,    16'h0400, 8'd1,  8'd0, 1'b1}, // R6 total 0
    '{1'b1, 8'h01, 8'h03, 16'hFFFF, 16'h2000, 8'd33, 8'd3, 1'b1}  // R5 long walk
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0, sel = 1'b0;
  logic [7:0]        wdata = '0;
  logic              dir_in = 1'b1, ptr = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic [15:0]       hlen = '0;
  logic              done = 1'b0;
  logic [PKT_W-1:0]  rx_len = '0;
  logic [7:0]        cnt_hi, cnt_lo;
  logic              busy, req;
  logic [PKT_W-1:0]  plen;
  logic [ADDR_W-1:0] raddr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_ep_count #(.MPS(MPS), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .dir_in_i(dir_in), .ptr_mode_i(ptr), .base_addr_i(base), .host_len_i(hlen),
    .pkt_done_i(done), .rx_len_i(rx_len), .cnt_hi_o(cnt_hi), .cnt_lo_o(cnt_lo),
    .busy_o(busy), .pkt_req_o(req), .pkt_len_o(plen), .rd_addr_o(raddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_done(input logic [PKT_W-1:0] rl);
    @(negedge clk); done = 1'b1; rx_len = rl;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hi", cnt_hi, 0);
    check("R1 lo", cnt_lo, 0);
    check("R1 busy", busy, 0);
    check("R1 req", req, 0);

    // high write stores and never arms
    wr(1'b0, 8'hA5);
    check("R2 hi stored", cnt_hi, 8'hA5);
    check("R3 hi no arm", busy, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      dir_in = 1'b1; ptr = VECS[v].ptr; base = VECS[v].base; hlen = VECS[v].hlen;
      wr(1'b0, VECS[v].hi);
      wr(1'b1, VECS[v].lo);
      check("R3 busy after arm", busy, VECS[v].arm);
      check("R3 req after arm", req, VECS[v].arm);
      check("R4 lo stored", cnt_lo, VECS[v].lo);
      for (int p = 0; p < VECS[v].npk; p++) begin
        check("R5 pkt req", req, 1);
        check("R5 pkt len", plen,
              (p == VECS[v].npk - 1) ? 32'(VECS[v].last) : MPS);
        check("R5 pkt addr", raddr,
              VECS[v].ptr ? 32'(VECS[v].base) + 32'(p * MPS) : 0);
        check("R8 busy mid", busy, 1);
        pulse_done('0);
      end
      check("R6 end busy", busy, 0);
      check("R2 hi kept", cnt_hi, VECS[v].hi);
    end

    // OUT: any low value arms, count reflects received bytes
    dir_in = 1'b0; ptr = 1'b0;
    wr(1'b0, 8'h33);
    wr(1'b1, 8'hE7);
    check("R7 out busy", busy, 1);
    check("R7 out cap", plen, MPS);
    wr(1'b0, 8'h44);
    check("R8 hi ignored busy", cnt_hi, 8'h33);
    wr(1'b1, 8'h11);
    check("R8 lo ignored busy", cnt_lo, 8'hE7);
    pulse_done(PKT_W'(6));
    check("R7 out hi zero", cnt_hi, 0);
    check("R7 out lo", cnt_lo, 6);
    check("R7 out idle", busy, 0);
    wr(1'b1, 8'h00);
    check("R7 rearm", busy, 1);
    pulse_done(PKT_W'(8));
    check("R7 out full", cnt_lo, 8);

    // busy IN walk: low write does not re-arm or resize
    dir_in = 1'b1; ptr = 1'b1; base = 16'h0500; hlen = 16'd100;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd12);
    wr(1'b1, 8'd1);
    check("R8 lo kept", cnt_lo, 12);
    check("R8 len1", plen, 8);
    pulse_done('0);
    check("R8 len2", plen, 4);
    check("R5 addr2", raddr, 16'h0508);
    pulse_done('0);
    check("R8 done", busy, 0);

    // stray done while idle
    pulse_done(PKT_W'(3));
    check("R9 idle busy", busy, 0);
    check("R9 idle lo", cnt_lo, 12);
    check("R9 idle hi", cnt_hi, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule